// File: doc/BRIEF.md
# Loopback UART Register Model

This block is a byte-wide register file laid out like a common 16550-style serial port, with no serial line behind it. Each byte written to the data offset goes into an internal circular buffer, and each read of that offset takes the oldest byte back out. Software therefore sees its own transmitted bytes come back as received data. The block also models the divisor latch, the FIFO control, line status, modem status and interrupt identification. All status values come from the buffer occupancy, a sticky overrun flag and the stored control registers.

Access goes through a plain synchronous port with a 3-bit offset, separate write and read strobes, and 8-bit write and read data. Read data is combinational from the current offset and state. A read's side effect, the removal of a byte, happens at the clock edge that ends the read. Defined events produce a one-cycle interrupt pulse in the cycle after the access that caused them. If write and read strobes are both high in the same cycle, only the write takes effect.

Top module: `loop_uart`

## Requirements
- R1: After synchronous active-low reset, line status reads 0x60, identification reads 0xC1, modem status reads 0xB3, interrupt enable and line control read 0x00, and the buffer capacity is 16.
- R2: Bytes written at offset 0 with line control bit 7 clear are read back at offset 0 in write order; the buffer holds 16 bytes, and its pointers wrap across repeated fills.
- R3: A write to offset 0 while the buffer holds its capacity drops the byte and sets overrun (line status bit 1); the next accepted write clears overrun. Capacity is 16 when FIFO control bit 0 was last written 1, and 1 when it was written 0.
- R4: A write to offset 2 with bit 1 or bit 2 set empties the buffer and leaves overrun unchanged.
- R5: With line control bit 7 set, offsets 0 and 1 read and write the divisor low and high bytes and leave the buffer untouched. A line control write with bit 7 set clears the divisor to zero.
- R6: A read of offset 1 with line control bit 7 clear returns only the low 4 bits of the stored interrupt enable value.
- R7: Line status (offset 5) has bit 0 set when the buffer is non-empty, bit 1 set when overrun is set, and bits 5 and 6 set when the buffer is empty.
- R8: Modem status (offset 6) always has bits 1, 5 and 7 set. Bits 0 and 4 are also set when modem control bit 5 is clear, or when it is set and the buffer is below capacity.
- R9: Identification (offset 2) reads 0xC0 OR a code for the highest-priority pending source: 0x6 when enable bit 2 is set and overrun is set; 0x4 when enable bit 0 is set and the buffer is non-empty; 0x2 when enable bit 1 is set and the buffer is empty; 0x0 when enable bit 3 is set and modem control bit 0 or 1 is set; 0x1 when no source is pending.
- R10: `irqPulse` is high for exactly the cycle after any of these accesses: a data write that makes the count 1 with enable bit 0 set; a dropped data write with enable bit 2 set; an interrupt enable write with bit 1 set while the buffer is empty; a data read that leaves the buffer empty with enable bit 1 set; a modem control write with bit 0, 1 or 3 set while enable bit 3 is set. It is low after any other access.
- R11: A data read from an empty buffer returns 0x00. Offset 7 is plain read/write storage. Writes to offsets 5 and 6 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| regOffset | input | 3 | Register offset |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the current offset |
| irqPulse | output | 1 | One-cycle interrupt event |

## Verification
The hardest state to reach is overrun together with an empty buffer. That state decides whether the line-status source still outranks transmit-empty in the identification value. The stimulus fills all sixteen slots, writes once more to force a drop, and then clears the buffer through FIFO control, so overrun outlives its cause. A single accepted write then has to lower the code to receive-data, and the read that drains it has to lower it to transmit-empty and raise a pulse.

// File: rtl/loop_uart_pkg.sv
package loop_uart_pkg;
  typedef enum logic [2:0] {
    OFS_DATA    = 3'd0,
    OFS_IEN     = 3'd1,
    OFS_IDFC    = 3'd2,
    OFS_LCTL    = 3'd3,
    OFS_MCTL    = 3'd4,
    OFS_LSTAT   = 3'd5,
    OFS_MSTAT   = 3'd6,
    OFS_SCRATCH = 3'd7
  } regOfs_e;

  typedef struct packed {
    logic       push;
    logic       drop;
    logic       pop;
    logic       clear;
    logic [7:0] pushData;
  } fifoCmd_t;

  localparam int IEN_RX   = 0;
  localparam int IEN_TXE  = 1;
  localparam int IEN_LINE = 2;
  localparam int IEN_MDM  = 3;
  localparam int LCTL_DIV = 7;
  localparam int MCTL_AFE = 5;
endpackage

// File: rtl/loop_uart_fifo.sv
module loop_uart_fifo
  import loop_uart_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = PW + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  fifoCmd_t      cmd,
  output logic [7:0]    headData,
  output logic [CW-1:0] count,
  output logic          overrun
);
  logic [7:0]    slot [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;

  always_ff @(posedge clk) begin
    for (int s = 0; s < DEPTH; s++) begin
      if (!rstN) slot[s] <= '0;
      else if (cmd.push && wrPtr == PW'(s)) slot[s] <= cmd.pushData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0; rdPtr <= '0; count <= '0; overrun <= 1'b0;
    end else begin
      if (cmd.clear) begin
        wrPtr <= '0; rdPtr <= '0; count <= '0;
      end else if (cmd.push) begin
        wrPtr <= wrPtr + 1'b1;
        count <= count + 1'b1;
      end else if (cmd.pop) begin
        rdPtr <= rdPtr + 1'b1;
        count <= count - 1'b1;
      end
      if (cmd.drop) overrun <= 1'b1;
      else if (cmd.push) overrun <= 1'b0;
    end
  end

  assign headData = slot[rdPtr];

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    cmd.push |-> count < CW'(DEPTH));
  a_r2_count_step: assert property (@(posedge clk) disable iff (!rstN)
    cmd.push |=> count == $past(count) + 1'b1);
  a_r4_clear_empties: assert property (@(posedge clk) disable iff (!rstN)
    cmd.clear |=> count == '0);
  a_r3_drop_sets_overrun: assert property (@(posedge clk) disable iff (!rstN)
    cmd.drop |=> overrun);
  a_r11_no_pop_empty: assert property (@(posedge clk) disable iff (!rstN)
    cmd.pop |-> count != '0);
endmodule

// File: rtl/loop_uart_ctrl.sv
module loop_uart_ctrl
  import loop_uart_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int TRIG  = 1,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = PW + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [2:0]    regOffset,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic [7:0]    wrData,
  input  logic [7:0]    headData,
  input  logic [CW-1:0] count,
  input  logic          overrun,
  output fifoCmd_t      cmd,
  output logic [7:0]    rdData,
  output logic          irqPulse
);
  logic [3:0]    ienReg;
  logic [7:0]    lctlReg, mctlReg, scrReg;
  logic [15:0]   divisor;
  logic          fifoOn;
  logic [CW-1:0] capLimit;
  logic          isEmpty, isFull, divMode, wrAcc, rdAcc;
  logic [2:0]    idCode;
  logic          evRx, evOvr, evIen, evDrain, evModem;
  regOfs_e       ofs;

  assign ofs      = regOfs_e'(regOffset);
  assign capLimit = fifoOn ? CW'(DEPTH) : CW'(1);
  assign isEmpty  = (count == '0);
  assign isFull   = (count >= capLimit);
  assign divMode  = lctlReg[LCTL_DIV];
  assign wrAcc    = wrEn;
  assign rdAcc    = rdEn && !wrEn;

  always_comb begin
    cmd          = '0;
    cmd.pushData = wrData;
    cmd.push  = wrAcc && ofs == OFS_DATA && !divMode && !isFull;
    cmd.drop  = wrAcc && ofs == OFS_DATA && !divMode && isFull;
    cmd.pop   = rdAcc && ofs == OFS_DATA && !divMode && !isEmpty;
    cmd.clear = wrAcc && ofs == OFS_IDFC && (wrData[1] || wrData[2]);
  end

  always_comb begin
    if (ienReg[IEN_LINE] && overrun)                    idCode = 3'h6;
    else if (ienReg[IEN_RX] && count >= CW'(TRIG))      idCode = 3'h4;
    else if (ienReg[IEN_TXE] && isEmpty)                idCode = 3'h2;
    else if (ienReg[IEN_MDM] && (mctlReg[0] || mctlReg[1])) idCode = 3'h0;
    else                                                idCode = 3'h1;
  end

  always_comb begin
    rdData = 8'h00;
    unique case (ofs)
      OFS_DATA:    rdData = divMode ? divisor[7:0] : (isEmpty ? 8'h00 : headData);
      OFS_IEN:     rdData = divMode ? divisor[15:8] : {4'h0, ienReg};
      OFS_IDFC:    rdData = {5'b11000, idCode};
      OFS_LCTL:    rdData = lctlReg;
      OFS_MCTL:    rdData = mctlReg;
      OFS_LSTAT:   rdData = {1'b0, isEmpty, isEmpty, 3'b000, overrun, !isEmpty};
      OFS_MSTAT:   rdData = 8'hA2 | ((!mctlReg[MCTL_AFE] || !isFull) ? 8'h11 : 8'h00);
      OFS_SCRATCH: rdData = scrReg;
      default:     rdData = 8'h00;
    endcase
  end

  assign evRx    = cmd.push && ienReg[IEN_RX] && count == CW'(TRIG - 1);
  assign evOvr   = cmd.drop && ienReg[IEN_LINE];
  assign evIen   = wrAcc && ofs == OFS_IEN && !divMode && wrData[IEN_TXE] && isEmpty;
  assign evDrain = rdAcc && ofs == OFS_DATA && !divMode && ienReg[IEN_TXE] && count <= CW'(1);
  assign evModem = wrAcc && ofs == OFS_MCTL && ienReg[IEN_MDM] && (wrData & 8'h0B) != 8'h00;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ienReg <= '0; lctlReg <= '0; mctlReg <= '0; scrReg <= '0;
      divisor <= '0; fifoOn <= 1'b1; irqPulse <= 1'b0;
    end else begin
      irqPulse <= evRx || evOvr || evIen || evDrain || evModem;
      if (wrAcc) begin
        unique case (ofs)
          OFS_DATA:    if (divMode) divisor[7:0] <= wrData;
          OFS_IEN:     if (divMode) divisor[15:8] <= wrData;
                       else ienReg <= wrData[3:0];
          OFS_IDFC:    fifoOn <= wrData[0];
          OFS_LCTL: begin
            lctlReg <= wrData;
            if (wrData[LCTL_DIV]) divisor <= '0;
          end
          OFS_MCTL:    mctlReg <= wrData;
          OFS_SCRATCH: scrReg <= wrData;
          default: ;
        endcase
      end
    end
  end

  a_r10_irq_has_cause: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> $past(wrEn || rdEn));
  a_r5_div_spares_fifo: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regOffset == 3'd0 && divMode) |=> count == $past(count));
  a_r8_cts_without_afe: assert property (@(posedge clk) disable iff (!rstN)
    (regOffset == 3'd6 && !mctlReg[MCTL_AFE]) |-> rdData[4] && rdData[0]);
endmodule

// File: rtl/loop_uart.sv
module loop_uart
  import loop_uart_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int TRIG  = 1,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] regOffset,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output logic       irqPulse
);
  fifoCmd_t      cmd;
  logic [7:0]    headData;
  logic [CW-1:0] count;
  logic          overrun;

  loop_uart_ctrl #(.DEPTH(DEPTH), .TRIG(TRIG)) ctrl_i (
    .clk(clk), .rstN(rstN), .regOffset(regOffset), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .headData(headData), .count(count), .overrun(overrun),
    .cmd(cmd), .rdData(rdData), .irqPulse(irqPulse));

  loop_uart_fifo #(.DEPTH(DEPTH)) fifo_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .headData(headData),
    .count(count), .overrun(overrun));
endmodule

// File: tb/loop_uart_tb_top.sv
module loop_uart_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] regOffset = '0;
  logic       wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       irqPulse;

  int nChecks = 0, nFails = 0;
  bit finished = 0;
  logic [7:0] rdVal;
  logic irqSeen;

  always #(CLK_PERIOD/2) clk = ~clk;

  loop_uart dut_i (.clk(clk), .rstN(rstN), .regOffset(regOffset), .wrEn(wrEn),
    .rdEn(rdEn), .wrData(wrData), .rdData(rdData), .irqPulse(irqPulse));

  task automatic access(input logic [2:0] ofs, input logic wr, input logic [7:0] d);
    @(negedge clk);
    regOffset = ofs; wrEn = wr; rdEn = !wr; wrData = d;
    #1 rdVal = rdData;
    @(posedge clk);
    #1 irqSeen = irqPulse;
    wrEn = 1'b0; rdEn = 1'b0;
  endtask

  task automatic wr(input logic [2:0] ofs, input logic [7:0] d);
    access(ofs, 1'b1, d);
  endtask

  task automatic check8(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%02h expected 0x%02h", req, what, act, exp);
    end
  endtask

  task automatic expectRd(input string req, input logic [2:0] ofs, input logic [7:0] exp);
    access(ofs, 1'b0, 8'h00);
    check8(req, $sformatf("read offset %0d", ofs), rdVal, exp);
  endtask

  task automatic checkIrq(input string req, input logic exp);
    check8(req, "irqPulse", {7'b0, irqSeen}, {7'b0, exp});
  endtask

  task automatic testReset;
    expectRd("R1", 3'd5, 8'h60);
    expectRd("R1", 3'd2, 8'hC1);
    expectRd("R1", 3'd6, 8'hB3);
    expectRd("R1", 3'd1, 8'h00);
    expectRd("R1", 3'd3, 8'h00);
  endtask

  task automatic testOrder;
    for (int i = 0; i < 10; i++) wr(3'd0, 8'h10 + 8'(i));
    for (int i = 0; i < 10; i++) expectRd("R2", 3'd0, 8'h10 + 8'(i));
    for (int i = 0; i < 16; i++) wr(3'd0, 8'hA0 + 8'(i));
    expectRd("R7", 3'd5, 8'h01);
    for (int i = 0; i < 16; i++) expectRd("R2", 3'd0, 8'hA0 + 8'(i));
    expectRd("R7", 3'd5, 8'h60);
  endtask

  task automatic testOverflow;
    for (int i = 0; i < 16; i++) wr(3'd0, 8'h40 + 8'(i));
    wr(3'd0, 8'hEE);
    expectRd("R3", 3'd5, 8'h03);
    for (int i = 0; i < 16; i++) expectRd("R3", 3'd0, 8'h40 + 8'(i));
    expectRd("R11", 3'd0, 8'h00);
    expectRd("R7", 3'd5, 8'h62);
    wr(3'd0, 8'h5C);
    expectRd("R3", 3'd5, 8'h01);
    expectRd("R3", 3'd0, 8'h5C);
    wr(3'd2, 8'h00);
    wr(3'd0, 8'h11);
    wr(3'd0, 8'h22);
    expectRd("R3", 3'd5, 8'h03);
    expectRd("R3", 3'd0, 8'h11);
    expectRd("R3", 3'd5, 8'h62);
    wr(3'd0, 8'h33);
    expectRd("R3", 3'd0, 8'h33);
    wr(3'd2, 8'h01);
    expectRd("R3", 3'd5, 8'h60);
  endtask

  task automatic testClear;
    for (int i = 0; i < 3; i++) wr(3'd0, 8'h70 + 8'(i));
    wr(3'd2, 8'h03);
    expectRd("R4", 3'd5, 8'h60);
    wr(3'd0, 8'h81); wr(3'd0, 8'h82);
    wr(3'd2, 8'h05);
    expectRd("R4", 3'd0, 8'h00);
  endtask

  task automatic testDivisor;
    wr(3'd0, 8'h55);
    wr(3'd3, 8'h80);
    wr(3'd0, 8'h34);
    wr(3'd1, 8'h12);
    expectRd("R5", 3'd0, 8'h34);
    expectRd("R5", 3'd1, 8'h12);
    expectRd("R5", 3'd5, 8'h01);
    wr(3'd3, 8'h83);
    expectRd("R5", 3'd0, 8'h00);
    expectRd("R5", 3'd1, 8'h00);
    wr(3'd3, 8'h03);
    expectRd("R5", 3'd3, 8'h03);
    expectRd("R5", 3'd0, 8'h55);
    expectRd("R5", 3'd1, 8'h00);
  endtask

  task automatic testIenMask;
    wr(3'd1, 8'hF5);
    expectRd("R6", 3'd1, 8'h05);
    wr(3'd1, 8'h00);
  endtask

  task automatic testModemStatus;
    wr(3'd4, 8'h20);
    expectRd("R8", 3'd6, 8'hB3);
    for (int i = 0; i < 16; i++) wr(3'd0, 8'(i));
    expectRd("R8", 3'd6, 8'hA2);
    wr(3'd4, 8'h00);
    expectRd("R8", 3'd6, 8'hB3);
    wr(3'd2, 8'h03);
    wr(3'd4, 8'h20);
    expectRd("R8", 3'd6, 8'hB3);
    wr(3'd4, 8'h00);
  endtask

  task automatic testInterrupts;
    wr(3'd1, 8'h0F);
    checkIrq("R10", 1'b1);
    expectRd("R9", 3'd2, 8'hC2);
    wr(3'd0, 8'h77);
    checkIrq("R10", 1'b1);
    expectRd("R9", 3'd2, 8'hC4);
    wr(3'd0, 8'h78);
    checkIrq("R10", 1'b0);
    for (int i = 0; i < 14; i++) wr(3'd0, 8'(i));
    wr(3'd0, 8'hFF);
    checkIrq("R10", 1'b1);
    expectRd("R9", 3'd2, 8'hC6);
    wr(3'd2, 8'h03);
    checkIrq("R10", 1'b0);
    expectRd("R4", 3'd5, 8'h62);
    expectRd("R9", 3'd2, 8'hC6);
    wr(3'd0, 8'h01);
    checkIrq("R10", 1'b1);
    expectRd("R9", 3'd2, 8'hC4);
    expectRd("R9", 3'd0, 8'h01);
    checkIrq("R10", 1'b1);
    expectRd("R9", 3'd2, 8'hC2);
    expectRd("R11", 3'd0, 8'h00);
    checkIrq("R10", 1'b1);
    wr(3'd1, 8'h08);
    checkIrq("R10", 1'b0);
    expectRd("R9", 3'd2, 8'hC1);
    wr(3'd4, 8'h01);
    checkIrq("R10", 1'b1);
    expectRd("R9", 3'd2, 8'hC0);
    wr(3'd4, 8'h08);
    checkIrq("R10", 1'b1);
    expectRd("R9", 3'd2, 8'hC1);
    wr(3'd1, 8'h00);
    wr(3'd4, 8'h03);
    checkIrq("R10", 1'b0);
    expectRd("R9", 3'd2, 8'hC1);
    wr(3'd4, 8'h00);
  endtask

  task automatic testScratchIgnored;
    wr(3'd7, 8'h5A);
    expectRd("R11", 3'd7, 8'h5A);
    wr(3'd5, 8'hFF);
    wr(3'd6, 8'h00);
    expectRd("R11", 3'd5, 8'h60);
    expectRd("R11", 3'd6, 8'hB3);
    expectRd("R11", 3'd0, 8'h00);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    testReset();
    testOrder();
    testOverflow();
    testClear();
    testDivisor();
    testIenMask();
    testModemStatus();
    testInterrupts();
    testScratchIgnored();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule